// File: doc/BRIEF.md
# Scanline Vertical Counter Encoder

This block tracks which scanline of a video frame is being produced and turns that line number into the 8-bit vertical count that a display processor reports to software. A frame-start strobe resets the line to zero and latches the video standard (525/60 or 625/50 style), the 240-line mode bit and the interlace field. Each line-advance strobe then moves the line forward by one.

The reported count equals the line number only during the active area. On the first blanking line it reports a fixed marker. Further into blanking it folds back at a standard-dependent point, so the 8-bit value stays continuous across the frame. In double-resolution interlace the count uses a shifted encoding. A one-cycle pulse marks entry into vertical blank.

Top module: `vcount_encoder`

## Requirements
- R1: After reset the raw line is 0, the encoded count is 0x00, the blank pulse is low, and the latched mode is the 262-line standard with normal encoding.
- R2: A frame-start strobe sets the raw line to 0 on the next edge and latches the mode inputs. It takes priority over a line-advance strobe in the same cycle.
- R3: A line-advance strobe raises the raw line by one. At the last line of the frame (261 for the 262-line standard, 312 for the 313-line standard) the line holds until the next frame start.
- R4: The active area is 224 lines. It is 240 lines only when the 313-line standard and the 240-line bit are both latched. The 240-line bit is ignored in the 262-line standard.
- R5: With normal encoding, the count on an active line equals the line number's low 8 bits.
- R6: Double-resolution encoding applies only when the interlace field is 2'b11. On an active line the count is then {line[6:0], line[7]}. The field values 2'b00, 2'b01 and 2'b10 all give normal encoding.
- R7: On the line equal to the active length, the count is 0xE0, or 0xC1 with double-resolution encoding.
- R8: On later lines the line is adjusted before it is encoded. If the line is at least 235 (262-line standard), 6 is subtracted; if it is at least 259 (313-line standard), 56 is subtracted. With normal encoding the count is the adjusted value's low 8 bits.
- R9: On those later lines with double-resolution encoding, the count is {adjusted[6:0], 1'b1}.
- R10: The blank pulse is high for exactly the one cycle in which the raw line first equals the active length.
- R11: Changes to the mode inputs between frame starts do not change the count, the frame length or the active length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Begin a new frame; latch modes |
| line_adv | input | 1 | Advance to the next scanline |
| std_pal | input | 1 | 1 selects the 313-line standard |
| tall_mode | input | 1 | Requests the 240-line active area |
| ilace_mode | input | 2 | Interlace field; 2'b11 selects double resolution |
| vcount | output | 8 | Encoded vertical count |
| line_num | output | 9 | Raw scanline number |
| vblank_pulse | output | 1 | One-cycle pulse on entering vertical blank |

## Verification
The assertions assume that the strobes are sampled cleanly at the clock edge. They also assume that mode inputs may change at any time, because only their latched copies matter, so any legal waveform on those pins is accepted. The stimulus changes inputs only on the falling edge and always opens a frame with a frame-start strobe before advancing lines. Some directed cases deliberately advance past the frame end, flip the mode pins mid-frame, and raise both strobes together, to exercise the hold, latch and priority behaviour.

// File: rtl/vcount_encoder.sv
module vcount_encoder #(
  parameter int LW          = 9,
  parameter int NTSC_TOTAL  = 262,
  parameter int PAL_TOTAL   = 313,
  parameter int SHORT_ACT   = 224,
  parameter int TALL_ACT    = 240,
  parameter int NTSC_WRAP   = 235,
  parameter int PAL_WRAP    = 259,
  parameter int NTSC_BACK   = 6,
  parameter int PAL_BACK    = 56,
  parameter logic [7:0] VBL_CODE    = 8'hE0,
  parameter logic [7:0] VBL_CODE_I2 = 8'hC1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_adv,
  input  logic          std_pal,
  input  logic          tall_mode,
  input  logic [1:0]    ilace_mode,
  output logic [7:0]    vcount,
  output logic [LW-1:0] line_num,
  output logic          vblank_pulse
);

  logic [LW-1:0] line_q;
  logic          pal_q, tall_q, i2_q, pulse_q;

  wire [LW-1:0] act_lines = (pal_q && tall_q) ? LW'(TALL_ACT) : LW'(SHORT_ACT);
  wire [LW-1:0] last_line = pal_q ? LW'(PAL_TOTAL - 1) : LW'(NTSC_TOTAL - 1);
  wire [LW-1:0] wrap_at   = pal_q ? LW'(PAL_WRAP) : LW'(NTSC_WRAP);
  wire [LW-1:0] back_by   = pal_q ? LW'(PAL_BACK) : LW'(NTSC_BACK);
  wire [LW-1:0] adj       = (line_q >= wrap_at) ? line_q - back_by : line_q;
  wire          adv_ok    = line_adv && (line_q != last_line);

  wire [7:0] act_code   = i2_q ? {line_q[6:0], line_q[7]} : line_q[7:0];
  wire [7:0] blank_code = i2_q ? {adj[6:0], 1'b1} : adj[7:0];

  assign vcount = (line_q < act_lines)  ? act_code :
                  (line_q == act_lines) ? (i2_q ? VBL_CODE_I2 : VBL_CODE) :
                                          blank_code;
  assign line_num     = line_q;
  assign vblank_pulse = pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= '0;
      pal_q   <= 1'b0;
      tall_q  <= 1'b0;
      i2_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= !frame_start && adv_ok && ((line_q + LW'(1)) == act_lines);
      if (frame_start) begin
        line_q <= '0;
        pal_q  <= std_pal;
        tall_q <= tall_mode;
        i2_q   <= &ilace_mode;
      end else if (adv_ok) begin
        line_q <= line_q + LW'(1);
      end
    end
  end

  // R2
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> line_num == '0);

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_adv && !frame_start && line_q != last_line) |=> line_num == $past(line_num) + LW'(1));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && line_q == last_line) |=> $stable(line_num));

  // R3
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_num <= LW'(PAL_TOTAL - 1));

  // R10
  pulse_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |-> line_num == act_lines);

  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_pulse |=> !vblank_pulse);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(pal_q) && $stable(tall_q) && $stable(i2_q)));

  // R7
  vbl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_num == act_lines) |-> (vcount == VBL_CODE || vcount == VBL_CODE_I2));

endmodule

// File: tb/tb_vcount_encoder.sv
module tb_vcount_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0, line_adv = 1'b0, std_pal = 1'b0, tall_mode = 1'b0;
  logic [1:0] ilace_mode = 2'b00;
  logic [7:0] vcount;
  logic [8:0] line_num;
  logic vblank_pulse;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vcount_encoder dut (.clk, .rst_n, .frame_start, .line_adv, .std_pal, .tall_mode,
                      .ilace_mode, .vcount, .line_num, .vblank_pulse);

  // {pal, tall, ilace[1:0], line[8:0], expected count[7:0]}
  localparam int NV = 23;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0,1'b0,2'd0,9'd0,  8'h00}, // R5
    {1'b0,1'b0,2'd0,9'd100,8'h64}, // R5
    {1'b0,1'b0,2'd0,9'd223,8'hDF}, // R5 R4
    {1'b0,1'b0,2'd0,9'd224,8'hE0}, // R7
    {1'b0,1'b0,2'd0,9'd234,8'hEA}, // R8
    {1'b0,1'b0,2'd0,9'd235,8'hE5}, // R8
    {1'b0,1'b0,2'd0,9'd261,8'hFF}, // R8
    {1'b1,1'b0,2'd0,9'd224,8'hE0}, // R7 R4
    {1'b1,1'b0,2'd0,9'd258,8'h02}, // R8
    {1'b1,1'b0,2'd0,9'd259,8'hCB}, // R8
    {1'b1,1'b0,2'd0,9'd312,8'h00}, // R8
    {1'b1,1'b1,2'd0,9'd239,8'hEF}, // R4
    {1'b1,1'b1,2'd0,9'd240,8'hE0}, // R4 R7
    {1'b0,1'b1,2'd0,9'd224,8'hE0}, // R4
    {1'b0,1'b0,2'd3,9'd100,8'hC8}, // R6
    {1'b0,1'b0,2'd3,9'd200,8'h91}, // R6
    {1'b0,1'b0,2'd3,9'd224,8'hC1}, // R7
    {1'b0,1'b0,2'd3,9'd230,8'hCD}, // R9
    {1'b0,1'b0,2'd3,9'd261,8'hFF}, // R9
    {1'b1,1'b1,2'd3,9'd239,8'hDF}, // R6
    {1'b1,1'b0,2'd3,9'd312,8'h01}, // R9
    {1'b0,1'b0,2'd1,9'd200,8'hC8}, // R6
    {1'b1,1'b1,2'd3,9'd250,8'hF5}  // R9
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic goto_line(input logic p, input logic t, input logic [1:0] m, input int n);
    @(negedge clk);
    std_pal = p; tall_mode = t; ilace_mode = m; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      line_adv = 1'b1;
      @(negedge clk);
    end
    line_adv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 line", int'(line_num), 0);
    chk("R1 count", int'(vcount), 0);
    chk("R1 pulse", int'(vblank_pulse), 0);

    for (int v = 0; v < NV; v++) begin
      goto_line(VEC[v][20], VEC[v][19], VEC[v][18:17], int'(VEC[v][16:8]));
      chk("R4/R5/R6/R7/R8/R9 line", int'(line_num), int'(VEC[v][16:8]));
      chk("R4/R5/R6/R7/R8/R9 count", int'(vcount), int'(VEC[v][7:0]));
    end

    // R10: pulse exactly once on entering blank
    goto_line(1'b0, 1'b0, 2'd0, 223);
    chk("R10 before", int'(vblank_pulse), 0);
    line_adv = 1'b1;
    @(negedge clk);
    line_adv = 1'b0;
    chk("R10 line", int'(line_num), 224);
    chk("R10 high", int'(vblank_pulse), 1);
    @(negedge clk);
    chk("R10 low after", int'(vblank_pulse), 0);

    // R10 with tall active area: no pulse at 224
    goto_line(1'b1, 1'b1, 2'd0, 224);
    chk("R10 tall no pulse", int'(vblank_pulse), 0);

    // R3: hold at last line
    goto_line(1'b0, 1'b0, 2'd0, 270);
    chk("R3 hold ntsc", int'(line_num), 261);
    goto_line(1'b1, 1'b0, 2'd0, 330);
    chk("R3 hold pal", int'(line_num), 312);

    // R2: frame start wins over line advance
    goto_line(1'b0, 1'b0, 2'd0, 10);
    frame_start = 1'b1; line_adv = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; line_adv = 1'b0;
    chk("R2 priority", int'(line_num), 0);

    // R11: mode pins changed mid-frame have no effect
    goto_line(1'b0, 1'b0, 2'd0, 240);
    std_pal = 1'b1; tall_mode = 1'b1; ilace_mode = 2'd3;
    @(negedge clk);
    chk("R11 count", int'(vcount), 8'hEA);
    for (int i = 0; i < 60; i++) begin
      line_adv = 1'b1;
      @(negedge clk);
    end
    line_adv = 1'b0;
    chk("R11 frame length", int'(line_num), 261);
    chk("R11 count end", int'(vcount), 8'hFF);

    // R2: new modes take effect at the next frame start
    goto_line(1'b1, 1'b1, 2'd3, 0);
    chk("R2 latch line", int'(line_num), 0);
    for (int i = 0; i < 240; i++) begin
      line_adv = 1'b1;
      @(negedge clk);
    end
    line_adv = 1'b0;
    chk("R2 latch count", int'(vcount), 8'hC1);

    // R1: reset mid-frame
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 re-reset line", int'(line_num), 0);
    chk("R1 re-reset count", int'(vcount), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule